// File: doc/BRIEF.md
# Seconds and Nanoseconds Timebase

This block keeps wall-clock time as a 64-bit count of whole seconds together with a nanoseconds-within-the-second field. On every clock cycle the nanoseconds field grows by the fixed clock period in nanoseconds, `BUS_PERIOD_NS`. When the field reaches one second, it wraps and carries one into the seconds count. The counter never stops, and software reads it through a small register window.

Software finds the tick rate by reading the period register. It reads the time as seconds-low, then nanoseconds, then seconds-low again, and repeats the sequence until the two seconds reads agree. The block therefore latches nothing across registers. Writes to the time registers load a new time. Any nanoseconds value that is not a valid in-second value is loaded as zero.

The block has no state machine. Each cycle, the counter either advances by one step or, in a cycle that carries a time write, holds while the written field is replaced.

Top module: `timebase_sn`

## Requirements
- R1: Synchronous active-high reset sets seconds and nanoseconds to 0 and sets rdata to 0.
- R2: The register at byte offset 0x18 reads back `BUS_PERIOD_NS`. Writes to it change nothing.
- R3: In a cycle without a time write, the nanoseconds value grows by exactly `BUS_PERIOD_NS` when the sum stays below 1,000,000,000.
- R4: When the sum reaches or passes 1,000,000,000, the new nanoseconds value is the sum minus 1,000,000,000. The 64-bit seconds count also rises by one, with carry from the low word into the high word.
- R5: The nanoseconds value is always below 1,000,000,000.
- R6: A write to offset 0x20 loads the upper 32 seconds bits, a write to offset 0x24 loads the lower 32 seconds bits, and a write to offset 0x28 loads nanoseconds. A nanoseconds write of 1,000,000,000 or more loads 0.
- R7: In a cycle that writes 0x20, 0x24 or 0x28, no field advances and no carry occurs. Fields that are not written keep their value.
- R8: A read strobe (`rd_en` high) at an address returns, on rdata after that clock edge, the register value held before the edge. Nanoseconds are zero-extended to 32 bits. Unmapped offsets return 0. While `rd_en` is low, rdata holds its value.
- R9: Writes to unmapped offsets are ignored, and time keeps advancing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that `BUS_PERIOD_NS` lies between 1 and 999,999,999. They also assume that reset is held for at least one clock edge before any check, so every `$past` term sees reset values. They make no assumption about when reads and writes arrive, and they allow a read and a write in the same cycle. The bench drives one strobe at a time, on the falling edge, with the default period of 4 ns. Every nanoseconds value it loads is either a valid in-second value or a deliberately out-of-range value meant to exercise the clamp.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

    localparam int unsigned NS_PER_SEC = 1_000_000_000;
    localparam int          NS_W       = 30;

    localparam int unsigned OFF_PERIOD = 32'h18;
    localparam int unsigned OFF_SEC_HI = 32'h20;
    localparam int unsigned OFF_SEC_LO = 32'h24;
    localparam int unsigned OFF_NSEC   = 32'h28;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PERIOD,
        SEL_SEC_HI,
        SEL_SEC_LO,
        SEL_NSEC
    } reg_sel_e;

endpackage

// File: rtl/timebase_regdec.sv
module timebase_regdec
    import timebase_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFF_PERIOD);
    localparam logic [ADDR_W-1:0] A_SEC_HI = ADDR_W'(OFF_SEC_HI);
    localparam logic [ADDR_W-1:0] A_SEC_LO = ADDR_W'(OFF_SEC_LO);
    localparam logic [ADDR_W-1:0] A_NSEC   = ADDR_W'(OFF_NSEC);

    always_comb begin
        sel = SEL_NONE;
        if (addr == A_PERIOD)      sel = SEL_PERIOD;
        else if (addr == A_SEC_HI) sel = SEL_SEC_HI;
        else if (addr == A_SEC_LO) sel = SEL_SEC_LO;
        else if (addr == A_NSEC)   sel = SEL_NSEC;
    end

endmodule

// File: rtl/timebase_nsec.sv
module timebase_nsec
    import timebase_pkg::*;
#(
    parameter int unsigned PERIOD_NS = 4,
    parameter int          DATA_W    = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [NS_W-1:0] nsec_q,
    output logic            carry
);

    localparam logic [NS_W:0] STEP = (NS_W + 1)'(PERIOD_NS);
    localparam logic [NS_W:0] LIMIT = (NS_W + 1)'(NS_PER_SEC);

    logic [NS_W:0]   sum;
    logic            wrap;
    logic [NS_W-1:0] ld_clamped;

    always_comb begin
        sum  = {1'b0, nsec_q} + STEP;
        wrap = (sum >= LIMIT);
        carry = !hold && wrap;
        if (64'(ld_val) >= 64'(NS_PER_SEC)) ld_clamped = '0;
        else                                ld_clamped = ld_val[NS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nsec_q <= '0;
        end else if (ld) begin
            nsec_q <= ld_clamped;
        end else if (!hold) begin
            if (wrap) nsec_q <= NS_W'(sum - LIMIT);
            else      nsec_q <= sum[NS_W-1:0];
        end
    end

    assert_nsec_range_R5: assert property (@(posedge clk) disable iff (rst)
        64'(nsec_q) < 64'(NS_PER_SEC));

    assert_wrap_small_R4: assert property (@(posedge clk) disable iff (rst)
        carry |=> (64'(nsec_q) < 64'(PERIOD_NS)));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!hold && !ld && !carry) |=> (64'(nsec_q) == 64'($past(nsec_q)) + 64'(PERIOD_NS)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && !ld) |=> $stable(nsec_q));

endmodule

// File: rtl/timebase_sec.sv
module timebase_sec #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic                ld_hi,
    input  logic                ld_lo,
    input  logic [DATA_W-1:0]   ld_val,
    input  logic                inc,
    output logic [2*DATA_W-1:0] sec_q
);

    localparam int SEC_W = 2 * DATA_W;

    logic [DATA_W-1:0] word_q [2];
    logic              ld_word [2];
    logic              lo_full;

    assign ld_word[0] = ld_lo;
    assign ld_word[1] = ld_hi;
    assign lo_full    = &word_q[0];

    for (genvar w = 0; w < 2; w++) begin : g_word
        logic step_en;
        if (w == 0) begin : g_lo
            assign step_en = inc;
        end else begin : g_hi
            assign step_en = inc && lo_full;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w] <= '0;
            end else if (ld_word[w]) begin
                word_q[w] <= ld_val;
            end else if (!hold && step_en) begin
                word_q[w] <= word_q[w] + 1'b1;
            end
        end

        assign sec_q[w*DATA_W +: DATA_W] = word_q[w];
    end

    assert_sec_inc_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !hold) |=> (sec_q == SEC_W'($past(sec_q) + 1'b1)));

    assert_sec_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld_hi && !ld_lo) |=> $stable(sec_q));

endmodule

// File: rtl/timebase_sn.sv
module timebase_sn
    import timebase_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int          DATA_W        = 32,
    parameter int unsigned BUS_PERIOD_NS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int SEC_W = 2 * DATA_W;

    reg_sel_e          sel;
    logic              wr_hi, wr_lo, wr_ns, time_wr;
    logic [NS_W-1:0]   nsec;
    logic              carry;
    logic [SEC_W-1:0]  sec;
    logic [DATA_W-1:0] rd_mux;

    timebase_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    assign wr_hi   = wr_en && (sel == SEL_SEC_HI);
    assign wr_lo   = wr_en && (sel == SEL_SEC_LO);
    assign wr_ns   = wr_en && (sel == SEL_NSEC);
    assign time_wr = wr_hi || wr_lo || wr_ns;

    timebase_nsec #(.PERIOD_NS(BUS_PERIOD_NS), .DATA_W(DATA_W)) u_ns (
        .clk    (clk),
        .rst    (rst),
        .hold   (time_wr),
        .ld     (wr_ns),
        .ld_val (wdata),
        .nsec_q (nsec),
        .carry  (carry)
    );

    timebase_sec #(.DATA_W(DATA_W)) u_sec (
        .clk    (clk),
        .rst    (rst),
        .hold   (time_wr),
        .ld_hi  (wr_hi),
        .ld_lo  (wr_lo),
        .ld_val (wdata),
        .inc    (carry),
        .sec_q  (sec)
    );

    always_comb begin
        unique case (sel)
            SEL_PERIOD: rd_mux = DATA_W'(BUS_PERIOD_NS);
            SEL_SEC_HI: rd_mux = sec[SEC_W-1:DATA_W];
            SEL_SEC_LO: rd_mux = sec[DATA_W-1:0];
            SEL_NSEC:   rd_mux = DATA_W'(nsec);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_rd_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    assert_sec_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        wr_ns |=> $stable(sec));

    assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> !$stable(nsec));

endmodule

// File: tb/timebase_sn_test.sv
`timescale 1ns/1ps
module timebase_sn_test;

    localparam int          ADDR_W = 8;
    localparam int          DATA_W = 32;
    localparam int unsigned P      = 4;
    localparam logic [7:0] A_PER = 8'h18, A_HI = 8'h20, A_LO = 8'h24, A_NS = 8'h28;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    timebase_sn #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_PERIOD_NS(P)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rdata", rdata, 0);
        rd(A_NS, v); check("R1 nsec", v, 0);
        rd(A_LO, v); check("R1 sec lo", v, 0);
        rd(A_HI, v); check("R1 sec hi", v, 0);
    endtask

    task automatic t_period();
        logic [31:0] v;
        rd(A_PER, v); check("R2 period", v, P);
        wr(A_PER, 32'd123);
        rd(A_PER, v); check("R2 period after write", v, P);
    endtask

    task automatic t_advance();
        logic [31:0] v;
        wr(A_NS, 32'd1000);
        idle(10);
        rd(A_NS, v); check("R3 ten steps", v, 1000 + 10 * P);
        rd(A_NS, v); check("R3 one step", v, 1000 + 11 * P);
    endtask

    task automatic t_exact_wrap();
        logic [31:0] v;
        wr(A_LO, 32'd5);
        wr(A_NS, 32'd999_999_992);
        idle(1);
        rd(A_NS, v); check("R4 before wrap", v, 32'd999_999_996);
        rd(A_LO, v); check("R4 sec after exact wrap", v, 6);
        rd(A_NS, v); check("R4 nsec after exact wrap", v, P);
    endtask

    task automatic t_overshoot_wrap();
        logic [31:0] v;
        wr(A_LO, 32'd40);
        wr(A_NS, 32'd999_999_999);
        rd(A_NS, v); check("R6 max valid nsec kept", v, 32'd999_999_999);
        rd(A_NS, v); check("R4 overshoot remainder", v, 3);
        rd(A_LO, v); check("R4 sec after overshoot", v, 41);
    endtask

    task automatic t_word_carry();
        logic [31:0] v;
        wr(A_LO, 32'hFFFF_FFFF);
        wr(A_HI, 32'd7);
        wr(A_NS, 32'd999_999_996);
        rd(A_HI, v); check("R6 sec hi loaded", v, 7);
        rd(A_HI, v); check("R4 carry into hi", v, 8);
        rd(A_LO, v); check("R4 lo wraps to zero", v, 0);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        wr(A_NS, 32'd1_000_000_000);
        rd(A_NS, v); check("R6 clamp at one second", v, 0);
        wr(A_NS, 32'hFFFF_FFFF);
        rd(A_NS, v); check("R6 clamp all ones", v, 0);
        rd(A_NS, v); check("R5 advances from clamp", v, P);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        wr(A_NS, 32'd500);
        rd(A_NS, v); check("R7 no step on nsec write", v, 500);
        wr(A_NS, 32'd100);
        wr(A_LO, 32'd9);
        wr(A_HI, 32'd2);
        rd(A_NS, v); check("R7 nsec held over seconds writes", v, 100);
        wr(A_NS, 32'd999_999_996);
        wr(A_LO, 32'd20);
        rd(A_LO, v); check("R7 no carry in write cycle", v, 20);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(A_NS, 32'd200);
        wr(8'h04, 32'd77);
        rd(A_NS, v); check("R9 unmapped write ignored", v, 200 + P);
        rd(8'h2C, v); check("R8 unmapped read zero", v, 0);
        rd(A_PER, v);
        idle(3);
        check("R8 rdata holds when idle", rdata, P);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        t_reset();
        t_period();
        t_advance();
        t_exact_wrap();
        t_overshoot_wrap();
        t_word_carry();
        t_clamp();
        t_freeze();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule